// File: doc/BRIEF.md
# Givens Rotation QR Row Updater

This block keeps an upper-triangular matrix R in on-chip registers and folds one new row x into it per update using Givens rotations. Data are signed two's-complement fixed point, W bits wide with F fractional bits; the defaults are 16 bits in Q3.12 form. The row arrives as a stream of N elements. After the last element is accepted, the block processes the columns in order. For column j it first runs a vectorize step on the pair (R[j][j], x[j]). This step finds the rotation that drives x[j] to zero, keeps that rotation as a cosine/sine pair, and writes the rotated length back to the diagonal. The block then runs one rotate step for each entry to the right of the diagonal. Each rotate step applies the stored pair to (R[j][i], x[i]) and updates both values.

The vectorize step needs an inverse square root. A short iterative unit provides it: the unit seeds from the leading-one position of r² + x² and then runs a fixed number of Newton-Raphson refinements. When both values of the pair are zero, the rotation falls back to the identity.

The number of row updates K is fixed when the block is built. Once K rows have been applied, the block raises a sticky completion flag and refuses further rows until reset. Any entry of R can be read at any time through a combinational index port.

Top module: `qr_givens_updater`

## Requirements
- R1: During reset (synchronous, active low), every entry of R is cleared to zero. After reset, busy and done are 0 and row_ready is 1.
- R2: A row is taken as N elements in column order, index 0 first, one element on each cycle where row_valid and row_ready are both high. row_ready is high only while the block is idle and fewer than K updates have been applied.
- R3: After an update, every diagonal entry R[j][j] is non-negative and equals sqrt(R[j][j]² + x'[j]²) within 48 LSB. Here x'[j] is the value of x[j] once the earlier columns have been processed, and the x element of the pair ends at zero.
- R4: After an update, each entry R[j][i] with i > j equals c·R[j][i] + s·x'[i] within 48 LSB, where c = r/n and s = x/n come from column j. The x element is replaced by c·x − s·r.
- R5: Entries below the diagonal always read exactly zero.
- R6: If R[j][j] and x[j] are both zero, the rotation is the identity (c = 1, s = 0): row j of R is unchanged and x passes unchanged to the later columns.
- R7: busy rises on the cycle after the last element is accepted. It stays high until the update has been written, and it falls within N·(ITER+3) + N² + 4 cycles.
- R8: After K updates, done is high and stays high until reset, and row_ready stays low. Any row_valid activity is then ignored: R does not change and busy stays low.
- R9: Any result that exceeds the signed W-bit range saturates to the nearest limit rather than wrapping. For example, a rotated length of 8.0 is stored as 32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_valid | input | 1 | Row element present |
| row_data | input | W | Row element, signed Q(W-F-1).F |
| row_ready | output | 1 | Block will accept a row element |
| busy | output | 1 | Update in progress |
| done | output | 1 | K updates have been applied (sticky) |
| rd_row | input | IW | Readout row index |
| rd_col | input | IW | Readout column index |
| rd_data | output | W | R entry at (rd_row, rd_col) |

## Verification
The hardest situations to reach from the ports are the degenerate vectorize step, where both values of the pair are exactly zero, and saturation of the rotated length. The first is reached with a row whose leading element is zero while R is still clear. It recurs after a saturating row, which leaves every later x element at exactly zero. Saturation is reached by feeding the most negative input value into a freshly reset R, which makes the rotated length exactly one step past the positive limit. Random rows drawn from a seeded generator then grow R over several updates. The results are compared against a real-valued Givens model with clamping.

// File: rtl/qr_pkg.sv
// Shared types and helpers for the Givens QR updater.
// Assumes widths of at most 64 bits for leading-one search and 128 bits for clamping.
package qr_pkg;

    typedef enum logic [2:0] {
        ST_LOAD,
        ST_VSTART,
        ST_VWAIT,
        ST_ROT,
        ST_FIN
    } qr_state_e;

    // Bit index of the most significant one (0 when the value is zero).
    function automatic int lead_one(input logic [63:0] v);
        int p;
        p = 0;
        for (int b = 0; b < 64; b++) begin
            if (v[b]) p = b;
        end
        return p;
    endfunction

    // Clamp a wide signed value into the signed range of w bits.
    function automatic logic signed [127:0] clamp(input logic signed [127:0] v, input int w);
        logic signed [127:0] hi;
        logic signed [127:0] lo;
        hi = (128'sd1 <<< (w - 1)) - 128'sd1;
        lo = -(128'sd1 <<< (w - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

endpackage

// File: rtl/qr_invsqrt.sv
// Iterative inverse square root: y = 1/sqrt(m).
// m is unsigned with MF fractional bits; y is unsigned with YF fractional bits.
// The seed is taken from the leading-one position and a two-entry mantissa table.
// ITER Newton-Raphson steps follow, and done pulses for one cycle with the result.
// Assumes m is nonzero; the caller handles the zero case.
module qr_invsqrt #(
    parameter int MW   = 32,
    parameter int MF   = 24,
    parameter int YF   = 24,
    parameter int ITER = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [MW-1:0] m,
    output logic [63:0]   y,
    output logic          done
);
    import qr_pkg::*;

    localparam int CW = $clog2(ITER + 1);
    localparam logic [63:0] SEED_EVEN = ((64'd1 << YF) * 64'd85) / 64'd100;
    localparam logic [63:0] SEED_ODD  = ((64'd1 << YF) * 64'd6) / 64'd10;

    logic [MW-1:0]  m_q;
    logic [63:0]    y_q;
    logic [63:0]    y0;
    logic [63:0]    y_nx;
    logic [CW-1:0]  cnt_q;
    logic           run_q;
    logic           done_q;

    // Seed: 2^(-h) times a mantissa picked by the parity of the exponent.
    always_comb begin
        int pe;
        int h;
        logic [63:0] base;
        pe   = lead_one(64'(m)) - MF;
        h    = pe >>> 1;
        base = pe[0] ? SEED_ODD : SEED_EVEN;
        if (h >= 0) y0 = base >> h;
        else        y0 = base << (-h);
    end

    // One Newton-Raphson step: y' = y * (3 - m*y^2) / 2, clamped at zero.
    always_comb begin
        logic [127:0] yy;
        logic [127:0] my;
        logic [127:0] three;
        logic [127:0] t;
        yy    = (128'(y_q) * 128'(y_q)) >> YF;
        my    = (128'(m_q) * yy) >> MF;
        three = 128'(3) << YF;
        t     = (my > three) ? 128'd0 : (three - my);
        y_nx  = 64'((128'(y_q) * t) >> (YF + 1));
    end

    // Load seed on start, then iterate a fixed number of times.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q    <= '0;
            y_q    <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else if (start) begin
            m_q    <= m;
            y_q    <= y0;
            cnt_q  <= CW'(ITER);
            run_q  <= 1'b1;
            done_q <= 1'b0;
        end else if (run_q) begin
            y_q   <= y_nx;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
                run_q  <= 1'b0;
                done_q <= 1'b1;
            end
        end else begin
            done_q <= 1'b0;
        end
    end

    assign y    = y_q;
    assign done = done_q;

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_result_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && m_q != '0) |-> (y_q != '0));

endmodule

// File: rtl/qr_rotate.sv
// Combinational rotate step: r' = c*r + s*x and x' = c*x - s*r, rescaled by F and saturated.
// Assumes c and s share the Q format of the data (F fractional bits).
module qr_rotate #(
    parameter int W = 16,
    parameter int F = 12
) (
    input  logic signed [W-1:0] c,
    input  logic signed [W-1:0] s,
    input  logic signed [W-1:0] r,
    input  logic signed [W-1:0] x,
    output logic signed [W-1:0] r_o,
    output logic signed [W-1:0] x_o
);
    import qr_pkg::*;

    // Four products, two sums, then arithmetic rescale and clamp.
    always_comb begin
        logic signed [127:0] pr;
        logic signed [127:0] px;
        pr  = 128'(c) * 128'(r) + 128'(s) * 128'(x);
        px  = 128'(c) * 128'(x) - 128'(s) * 128'(r);
        r_o = W'(clamp(pr >>> F, W));
        x_o = W'(clamp(px >>> F, W));
    end

endmodule

// File: rtl/qr_givens_updater.sv
// Givens QR row updater.
// Holds an N x N upper-triangular R and folds one streamed row x into it per update.
// For each column j, a vectorize step zeroes x[j] and stores the rotation (c, s).
// Rotate steps then apply (c, s) to the rest of row j.
// Assumes N >= 2, W <= 32 and that all values use F fractional bits.
module qr_givens_updater #(
    parameter int N    = 4,
    parameter int W    = 16,
    parameter int F    = 12,
    parameter int K    = 8,
    parameter int ITER = 5,
    parameter int YF   = 24,
    localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                row_valid,
    input  logic signed [W-1:0] row_data,
    output logic                row_ready,
    output logic                busy,
    output logic                done,
    input  logic [IW-1:0]       rd_row,
    input  logic [IW-1:0]       rd_col,
    output logic signed [W-1:0] rd_data
);
    import qr_pkg::*;

    localparam int KW = $clog2(K + 1);
    localparam int MW = 2 * W;

    qr_state_e            state;
    logic signed [W-1:0]  rmat [N][N];
    logic signed [W-1:0]  x_vec [N];
    logic [IW-1:0]        j_q, i_q, cnt_q;
    logic [KW-1:0]        upd_q;
    logic signed [W-1:0]  c_q, s_q;
    logic [MW-1:0]        m_q, m_cur;
    logic [63:0]          isq_y;
    logic                 isq_done;
    logic signed [W-1:0]  r_jj, x_j, c_v, s_v, n_v;
    logic signed [W-1:0]  rot_r_in, rot_x_in, rot_r, rot_x;

    assign r_jj     = rmat[j_q][j_q];
    assign x_j      = x_vec[j_q];
    assign rot_r_in = rmat[j_q][i_q];
    assign rot_x_in = x_vec[i_q];

    // Squared length of the current vectorize pair.
    always_comb begin
        logic signed [MW:0] sq;
        sq    = (MW+1)'(r_jj) * (MW+1)'(r_jj) + (MW+1)'(x_j) * (MW+1)'(x_j);
        m_cur = sq[MW-1:0];
    end

    // Vectorize results from the inverse square root: c = r*y, s = x*y, n = m*y.
    always_comb begin
        logic signed [127:0] y_ext;
        y_ext = $signed(128'(isq_y));
        c_v   = W'(clamp((128'(r_jj) * y_ext) >>> YF, W));
        s_v   = W'(clamp((128'(x_j) * y_ext) >>> YF, W));
        n_v   = W'(clamp($signed((128'(m_q) * 128'(isq_y)) >> (F + YF)), W));
    end

    qr_invsqrt #(.MW(MW), .MF(2 * F), .YF(YF), .ITER(ITER)) u_isq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (state == ST_VSTART),
        .m     (m_cur),
        .y     (isq_y),
        .done  (isq_done)
    );

    qr_rotate #(.W(W), .F(F)) u_rot (
        .c   (c_q),
        .s   (s_q),
        .r   (rot_r_in),
        .x   (rot_x_in),
        .r_o (rot_r),
        .x_o (rot_x)
    );

    // Sequencer: load row, then vectorize/rotate column by column, then count the update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_LOAD;
            for (int a = 0; a < N; a++) begin
                x_vec[a] <= '0;
                for (int b = 0; b < N; b++) rmat[a][b] <= '0;
            end
            j_q   <= '0;
            i_q   <= '0;
            cnt_q <= '0;
            upd_q <= '0;
            c_q   <= '0;
            s_q   <= '0;
            m_q   <= '0;
        end else begin
            case (state)
                ST_LOAD: begin
                    if (row_valid && row_ready) begin
                        x_vec[cnt_q] <= row_data;
                        if (cnt_q == IW'(N - 1)) begin
                            cnt_q <= '0;
                            j_q   <= '0;
                            state <= ST_VSTART;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_VSTART: begin
                    m_q   <= m_cur;
                    state <= ST_VWAIT;
                end
                ST_VWAIT: begin
                    if (isq_done) begin
                        if (m_q == '0) begin
                            c_q <= W'(1 << F);
                            s_q <= '0;
                            rmat[j_q][j_q] <= '0;
                        end else begin
                            c_q <= c_v;
                            s_q <= s_v;
                            rmat[j_q][j_q] <= n_v;
                        end
                        x_vec[j_q] <= '0;
                        if (j_q == IW'(N - 1)) begin
                            state <= ST_FIN;
                        end else begin
                            i_q   <= j_q + 1'b1;
                            state <= ST_ROT;
                        end
                    end
                end
                ST_ROT: begin
                    rmat[j_q][i_q] <= rot_r;
                    x_vec[i_q]     <= rot_x;
                    if (i_q == IW'(N - 1)) begin
                        j_q   <= j_q + 1'b1;
                        state <= ST_VSTART;
                    end else begin
                        i_q <= i_q + 1'b1;
                    end
                end
                ST_FIN: begin
                    upd_q <= upd_q + 1'b1;
                    state <= ST_LOAD;
                end
                default: state <= ST_LOAD;
            endcase
        end
    end

    assign row_ready = (state == ST_LOAD) && (upd_q < KW'(K));
    assign busy      = (state != ST_LOAD);
    assign done      = (upd_q == KW'(K));
    assign rd_data   = rmat[rd_row][rd_col];

    // Rotation pair magnitude, checked while rotations are applied.
    logic signed [MW:0] cs_sum;
    assign cs_sum = (MW+1)'(c_q) * (MW+1)'(c_q) + (MW+1)'(s_q) * (MW+1)'(s_q);
    localparam logic signed [MW:0] UNIT = (MW+1)'(1) <<< (2 * F);
    localparam logic signed [MW:0] CTOL = (MW+1)'(1) <<< (2 * F - 7);

    assert_unit_rotation_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROT) |-> (cs_sum > UNIT - CTOL && cs_sum < UNIT + CTOL));

    assert_pair_zeroed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROT) |-> (x_vec[j_q] == '0));

    assert_no_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !row_ready);

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && !row_ready));

    for (genvar ga = 0; ga < N; ga++) begin : g_row
        assert_diag_nonneg_R3: assert property (@(posedge clk) disable iff (!rst_n)
            rmat[ga][ga] >= 0);
        for (genvar gb = 0; gb < N; gb++) begin : g_col
            if (gb < ga) begin : g_low
                assert_lower_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
                    rmat[ga][gb] == '0);
            end else begin : g_up
                assert_frozen_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
                    done |=> $stable(rmat[ga][gb]));
            end
        end
    end

endmodule

// File: tb/qr_givens_updater_bench.sv
// Bench: directed corner rows plus seeded random rows, compared to a real-valued Givens model.
module qr_givens_updater_bench;

    localparam int N          = 4;
    localparam int W          = 16;
    localparam int F          = 12;
    localparam int K          = 8;
    localparam int ITER       = 5;
    localparam int IW         = 2;
    localparam int CLK_PERIOD = 10;
    localparam int TOL        = 48;
    localparam int LAT_MAX    = N * (ITER + 3) + N * N + 4;
    localparam real SCALE     = 4096.0;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                row_valid = 1'b0;
    logic signed [W-1:0] row_data = '0;
    logic                row_ready, busy, done;
    logic [IW-1:0]       rd_row = '0, rd_col = '0;
    logic signed [W-1:0] rd_data;

    int  n_checks = 0;
    int  n_fails  = 0;
    int  cyc      = 0;
    real rm [N][N];

    qr_givens_updater #(.N(N), .W(W), .F(F), .K(K), .ITER(ITER)) u_qr_givens_updater (
        .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .row_data(row_data),
        .row_ready(row_ready), .busy(busy), .done(done),
        .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog R7 actual=%0d expected<=%0d", cyc, 150000);
            report();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic real clampr(input real v);
        if (v > 32767.0 / SCALE) return 32767.0 / SCALE;
        if (v < -8.0) return -8.0;
        return v;
    endfunction

    task automatic model_clear();
        for (int a = 0; a < N; a++)
            for (int b = 0; b < N; b++) rm[a][b] = 0.0;
    endtask

    task automatic model_update(input int xr [N]);
        real xv [N];
        real r, xj, n, c, s, rr, xx;
        for (int e = 0; e < N; e++) xv[e] = real'(xr[e]) / SCALE;
        for (int j = 0; j < N; j++) begin
            r  = rm[j][j];
            xj = xv[j];
            if (r == 0.0 && xj == 0.0) begin
                c = 1.0;
                s = 0.0;
            end else begin
                n = $sqrt(r * r + xj * xj);
                c = r / n;
                s = xj / n;
                rm[j][j] = clampr(n);
            end
            xv[j] = 0.0;
            for (int i = j + 1; i < N; i++) begin
                rr = rm[j][i];
                xx = xv[i];
                rm[j][i] = clampr(c * rr + s * xx);
                xv[i]    = clampr(c * xx - s * rr);
            end
        end
    endtask

    // Compare every entry: R3 diagonal, R4 upper, R5 lower.
    task automatic check_all(input string tag);
        int exp_v;
        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
                rd_row = IW'(a);
                rd_col = IW'(b);
                #1;
                if (b < a) begin
                    chk(rd_data == 0, {"R5 lower ", tag}, int'(rd_data), 0);
                end else begin
                    exp_v = int'(rm[a][b] * SCALE);
                    if (a == b) begin
                        chk(rd_data >= 0, {"R3 sign ", tag}, int'(rd_data), exp_v);
                        chk((int'(rd_data) - exp_v) <= TOL && (exp_v - int'(rd_data)) <= TOL,
                            {"R3 diag ", tag}, int'(rd_data), exp_v);
                    end else begin
                        chk((int'(rd_data) - exp_v) <= TOL && (exp_v - int'(rd_data)) <= TOL,
                            {"R4 upper ", tag}, int'(rd_data), exp_v);
                    end
                end
            end
        end
    endtask

    // Stream one row (R2), then time the update (R7).
    task automatic send_row(input int xr [N]);
        int lat;
        for (int e = 0; e < N; e++) begin
            @(negedge clk);
            chk(row_ready == 1'b1, "R2 ready before element", int'(row_ready), 1);
            row_valid = 1'b1;
            row_data  = W'(xr[e]);
        end
        @(negedge clk);
        row_valid = 1'b0;
        chk(busy == 1'b1, "R7 busy after last element", int'(busy), 1);
        chk(row_ready == 1'b0, "R2 ready low while busy", int'(row_ready), 0);
        lat = 0;
        while (busy && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        chk(lat <= LAT_MAX, "R7 update latency", lat, LAT_MAX);
        model_update(xr);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    initial begin
        int xr [N];
        int seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        model_clear();
        repeat (2) @(negedge clk);
        do_reset();

        // R1: reset state.
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(row_ready == 1'b1, "R1 ready", int'(row_ready), 1);
        check_all("R1 after reset");

        // R6: leading element zero on a clear R gives an identity rotation on column 0.
        xr = '{0, 1000, -700, 300};
        send_row(xr);
        rd_row = 0; rd_col = 0; #1;
        chk(rd_data == 0, "R6 diag stays zero", int'(rd_data), 0);
        rd_row = 0; rd_col = 1; #1;
        chk(rd_data == 0, "R6 row untouched", int'(rd_data), 0);
        rd_row = 1; rd_col = 1; #1;
        chk(rd_data == 1000, "R6 x passed through", int'(rd_data), 1000);
        check_all("R6 row");

        // A directed row with negative leading element.
        xr = '{-1500, 400, 900, -2000};
        send_row(xr);
        check_all("directed negative");

        // Random rows up to K.
        for (int k = 2; k < K; k++) begin
            for (int e = 0; e < N; e++) xr[e] = int'($urandom_range(0, 4095)) - 2048;
            send_row(xr);
            check_all("random row");
        end

        // R8: done is sticky and further rows are ignored.
        @(negedge clk);
        chk(done == 1'b1, "R8 done after K", int'(done), 1);
        chk(row_ready == 1'b0, "R8 ready low after K", int'(row_ready), 0);
        for (int t = 0; t < 12; t++) begin
            row_valid = 1'b1;
            row_data  = W'(t * 211 - 900);
            @(negedge clk);
            chk(busy == 1'b0, "R8 ignored row keeps idle", int'(busy), 0);
            chk(done == 1'b1, "R8 done held", int'(done), 1);
        end
        row_valid = 1'b0;
        check_all("R8 unchanged");

        // R1 again: reset after completion clears everything.
        do_reset();
        chk(done == 1'b0, "R1 done cleared", int'(done), 0);
        chk(row_ready == 1'b1, "R1 ready again", int'(row_ready), 1);
        check_all("R1 second reset");

        // R9: most negative input makes a length of 8.0, which must saturate.
        xr = '{-32768, 1200, -300, 50};
        send_row(xr);
        rd_row = 0; rd_col = 0; #1;
        chk(rd_data == 32767, "R9 saturated diag", int'(rd_data), 32767);
        check_all("R9 row");

        // Follow with a random row on the saturated matrix.
        for (int e = 0; e < N; e++) xr[e] = int'($urandom_range(0, 4095)) - 2048;
        send_row(xr);
        check_all("after saturation");

        report();
        $finish;
    end

endmodule